// File: doc/BRIEF.md
# Asynchronous SRAM Bus Timing Monitor

This block watches the control, address and write-data pins of an asynchronous byte-wide static RAM bus. It samples them with a fast local clock and measures, in clock ticks, the intervals that the memory needs for correct operation. When an interval is too short, it raises a sticky error flag and bumps a saturating counter for that kind of error. It stores no memory data and drives nothing onto the bus. It is a passive observer that can sit beside a memory controller in a design, or on a bus under test.

A write is in progress only while both active-low strobes, write enable and chip select, are low. Either strobe may open this window and either may close it. Every write limit is measured against the edges that actually open and close the window, so a write ended by chip select is judged the same way as one ended by write enable. Reads are checked when the bus master signals the moment it samples the returned data. That sample must come a full access time after the latest address change or chip-select fall.

All pins pass through a two-flop synchroniser. A measured interval is reduced by a slack of one tick to cover synchroniser uncertainty. As a result, an interval that measures exactly the limit is still reported as a violation.

Top module: `sram_timing_monitor`

## Requirements
- R1: After synchronous reset, every error flag and every error counter reads zero.
- R2: A write window exists only while chip select and write enable are both low. Write enable low with chip select high, or chip select low with write enable high, raises no write error.
- R3: A window lasting fewer than LIM_WPW+SYNC_SLACK ticks sets flag bit 0. This applies whichever strobe ends the window.
- R4: If fewer than LIM_CSW+SYNC_SLACK ticks pass from the chip select fall to the end of the window, flag bit 1 is set.
- R5: If write data last changed fewer than LIM_DSU+SYNC_SLACK ticks before the window ends, flag bit 2 is set.
- R6: If the address last changed fewer than LIM_ASU+SYNC_SLACK ticks before the window ends, flag bit 3 is set. An address change on the sample where the window opens counts as the start of that interval.
- R7: An address change on any sample strictly inside a window, after its opening sample, sets flag bit 4.
- R8: A window that opens fewer than LIM_WGAP+SYNC_SLACK ticks after the previous window closed sets flag bit 5. A window that opens fewer than LIM_WCYC+SYNC_SLACK ticks after the previous window opened sets flag bit 6.
- R9: A rising edge of the read-sample input is checked only while chip select is low, write enable is high and output enable is low. If it comes fewer than LIM_RACC+SYNC_SLACK ticks after the latest address change or chip select fall, flag bit 7 is set. Any address change restarts this timer.
- R10: Each flag stays set until the clear input is sampled high. Clear zeroes all flags and counters and takes priority over a violation seen in the same cycle.
- R11: Counter i, at err_cnt_o[i*CNT_W +: CNT_W], rises by one for each violation of kind i. It stops at all ones.
- R12: Because of the one-tick slack, an interval equal to its limit is flagged, and an interval one tick longer than its limit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock; one period is one tick |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Synchronous clear of all flags and counters |
| cs_n_i | input | 1 | Observed chip select, active low |
| we_n_i | input | 1 | Observed write enable, active low |
| oe_n_i | input | 1 | Observed output enable, active low |
| addr_i | input | ADDR_W | Observed address bus |
| din_i | input | DATA_W | Observed write data |
| rd_smp_i | input | 1 | Bus master's read-data sample strobe; its rising edge is checked |
| err_flag_o | output | 8 | Sticky error flags, bit index = error kind |
| err_cnt_o | output | 8*CNT_W | Per-kind saturating occurrence counters |

## Verification
The hardest case to reach from the ports is an interval that lands exactly on a limit. The counts must match the requirements to the tick, and one limit must break while every other limit still passes. The stimulus changes the pins on the falling clock edge, so each level is seen for a whole number of samples. It also opens chip select well ahead of write enable, or holds the address steady, so that only one check is near its edge. Each boundary is then driven twice, one tick apart. The write-cycle limit cannot break alone under the default limits, so it is checked together with the gap limit, using the expected pair of flags.

// File: rtl/smon_pkg.sv
package smon_pkg;

  localparam int unsigned ERR_WPW  = 0;  // window too short
  localparam int unsigned ERR_CSW  = 1;  // chip select fall to window end
  localparam int unsigned ERR_DSU  = 2;  // data stable before window end
  localparam int unsigned ERR_ASU  = 3;  // address stable before window end
  localparam int unsigned ERR_AWC  = 4;  // address moved inside window
  localparam int unsigned ERR_WGAP = 5;  // recovery between windows
  localparam int unsigned ERR_WCYC = 6;  // window start to window start
  localparam int unsigned ERR_RACC = 7;  // read sampled before access time
  localparam int unsigned NERR     = 8;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/smon_sync.sv
module smon_sync #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end

endmodule

// File: rtl/smon_age.sv
module smon_age #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart_i,
  output logic [W-1:0] age_o
);

  // Ticks since the last restart: reads 1 on the sample after the event,
  // parks at all ones (treated as "long ago") after reset.
  always_ff @(posedge clk) begin
    if (rst)
      age_o <= '1;
    else if (restart_i)
      age_o <= W'(1);
    else if (age_o != '1)
      age_o <= age_o + 1'b1;
  end

endmodule

// File: rtl/smon_err_bank.sv
module smon_err_bank #(
  parameter int unsigned N     = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [N-1:0]     ev_i,
  output logic [N-1:0]     flag_o,
  output logic [N*CNT_W-1:0] cnt_o
);

  for (genvar i = 0; i < N; i++) begin : g_kind
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        flag_o[i] <= 1'b0;
        cnt_q     <= '0;
      end else if (ev_i[i]) begin
        flag_o[i] <= 1'b1;
        if (cnt_q != '1)
          cnt_q <= cnt_q + 1'b1;
      end
    end

    assign cnt_o[i*CNT_W +: CNT_W] = cnt_q;
  end

endmodule

// File: rtl/sram_timing_monitor.sv
module sram_timing_monitor
  import smon_pkg::*;
#(
  parameter int unsigned ADDR_W     = 19,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned SYNC_SLACK = 1,
  parameter int unsigned LIM_WPW    = 6,
  parameter int unsigned LIM_CSW    = 7,
  parameter int unsigned LIM_DSU    = 2,
  parameter int unsigned LIM_ASU    = 7,
  parameter int unsigned LIM_WGAP   = 4,
  parameter int unsigned LIM_WCYC   = 10,
  parameter int unsigned LIM_RACC   = 15
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_i,
  input  logic                    cs_n_i,
  input  logic                    we_n_i,
  input  logic                    oe_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       din_i,
  input  logic                    rd_smp_i,
  output logic [NERR-1:0]         err_flag_o,
  output logic [NERR*CNT_W-1:0]   err_cnt_o
);

  localparam int MAX_LIM = max2(max2(max2(LIM_WPW, LIM_CSW), max2(LIM_DSU, LIM_ASU)),
                                max2(max2(LIM_WGAP, LIM_WCYC), LIM_RACC));
  localparam int unsigned AGE_W = $clog2(MAX_LIM + SYNC_SLACK + 2) + 1;
  localparam int unsigned PW    = ADDR_W + DATA_W + 4;
  localparam int unsigned EW    = ADDR_W + DATA_W + 3;  // bits that need a previous sample
  localparam logic [PW-1:0] PIN_IDLE = {4'b0111, {(ADDR_W + DATA_W){1'b0}}};

  localparam logic [AGE_W-1:0] TH_WPW  = AGE_W'(LIM_WPW  + SYNC_SLACK);
  localparam logic [AGE_W-1:0] TH_CSW  = AGE_W'(LIM_CSW  + SYNC_SLACK);
  localparam logic [AGE_W-1:0] TH_DSU  = AGE_W'(LIM_DSU  + SYNC_SLACK);
  localparam logic [AGE_W-1:0] TH_ASU  = AGE_W'(LIM_ASU  + SYNC_SLACK);
  localparam logic [AGE_W-1:0] TH_WGAP = AGE_W'(LIM_WGAP + SYNC_SLACK);
  localparam logic [AGE_W-1:0] TH_WCYC = AGE_W'(LIM_WCYC + SYNC_SLACK);
  localparam logic [AGE_W-1:0] TH_RACC = AGE_W'(LIM_RACC + SYNC_SLACK);

  // ---------------- synchronised pins and one-sample history ----------------
  logic [PW-1:0] pin_s;
  logic [EW-1:0] pin_p;

  smon_sync #(.W(PW), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({oe_n_i, rd_smp_i, we_n_i, cs_n_i, din_i, addr_i}),
    .q_o (pin_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pin_p <= PIN_IDLE[EW-1:0];
    else     pin_p <= pin_s[EW-1:0];
  end

  logic [ADDR_W-1:0] addr_c, addr_p;
  logic [DATA_W-1:0] din_c, din_p;
  logic cs_c, cs_p, we_c, we_p, rd_c, rd_p, oe_c;

  assign addr_c = pin_s[ADDR_W-1:0];
  assign addr_p = pin_p[ADDR_W-1:0];
  assign din_c  = pin_s[ADDR_W +: DATA_W];
  assign din_p  = pin_p[ADDR_W +: DATA_W];
  assign cs_c   = pin_s[ADDR_W+DATA_W];
  assign cs_p   = pin_p[ADDR_W+DATA_W];
  assign we_c   = pin_s[ADDR_W+DATA_W+1];
  assign we_p   = pin_p[ADDR_W+DATA_W+1];
  assign rd_c   = pin_s[ADDR_W+DATA_W+2];
  assign rd_p   = pin_p[ADDR_W+DATA_W+2];
  assign oe_c   = pin_s[ADDR_W+DATA_W+3];

  // ---------------- events ----------------
  logic win_c, win_p, win_open, win_close, cs_fall, addr_chg, din_chg, rd_edge, reading;

  assign win_c     = !cs_c && !we_c;
  assign win_p     = !cs_p && !we_p;
  assign win_open  = win_c && !win_p;
  assign win_close = !win_c && win_p;
  assign cs_fall   = !cs_c && cs_p;
  assign addr_chg  = addr_c != addr_p;
  assign din_chg   = din_c != din_p;
  assign rd_edge   = rd_c && !rd_p;
  assign reading   = !cs_c && we_c && !oe_c;

  // ---------------- interval timers ----------------
  localparam int unsigned NAGE = 6;
  localparam int unsigned A_OPEN = 0, A_CLOSE = 1, A_CS = 2, A_ADDR = 3, A_DIN = 4, A_RD = 5;

  logic [NAGE-1:0]  age_restart;
  logic [AGE_W-1:0] age [NAGE];

  assign age_restart[A_OPEN]  = win_open;
  assign age_restart[A_CLOSE] = win_close;
  assign age_restart[A_CS]    = cs_fall;
  assign age_restart[A_ADDR]  = addr_chg;
  assign age_restart[A_DIN]   = din_chg;
  assign age_restart[A_RD]    = addr_chg || cs_fall;

  for (genvar k = 0; k < NAGE; k++) begin : g_age
    smon_age #(.W(AGE_W)) u_age (
      .clk       (clk),
      .rst       (rst),
      .restart_i (age_restart[k]),
      .age_o     (age[k])
    );
  end

  // A change seen on the checking sample itself means zero stable ticks.
  logic [AGE_W-1:0] addr_stable, din_stable, rd_elapsed;
  assign addr_stable = addr_chg ? '0 : age[A_ADDR];
  assign din_stable  = din_chg  ? '0 : age[A_DIN];
  assign rd_elapsed  = age_restart[A_RD] ? '0 : age[A_RD];

  // ---------------- violation detection ----------------
  logic [NERR-1:0] ev;

  always_comb begin
    ev           = '0;
    ev[ERR_WPW]  = win_close && (age[A_OPEN] < TH_WPW);
    ev[ERR_CSW]  = win_close && (age[A_CS] < TH_CSW);
    ev[ERR_DSU]  = win_close && (din_stable < TH_DSU);
    ev[ERR_ASU]  = win_close && (addr_stable < TH_ASU);
    ev[ERR_AWC]  = win_c && win_p && addr_chg;
    ev[ERR_WGAP] = win_open && (age[A_CLOSE] < TH_WGAP);
    ev[ERR_WCYC] = win_open && (age[A_OPEN] < TH_WCYC);
    ev[ERR_RACC] = rd_edge && reading && (rd_elapsed < TH_RACC);
  end

  smon_err_bank #(.N(NERR), .CNT_W(CNT_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (clr_i),
    .ev_i   (ev),
    .flag_o (err_flag_o),
    .cnt_o  (err_cnt_o)
  );

endmodule

// File: rtl/smon_checker.sv
module smon_checker #(
  parameter int unsigned NERR  = 8,
  parameter int unsigned CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clr_i,
  input logic                  rd_smp_i,
  input logic [NERR-1:0]       err_flag_o,
  input logic [NERR*CNT_W-1:0] err_cnt_o
);

  // R10: flags never drop without a clear
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((err_flag_o & $past(err_flag_o)) == $past(err_flag_o)));

  // R10: clear empties flags and counters on the next sample
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (err_flag_o == '0) && (err_cnt_o == '0));

  // R9: a read-access flag can only rise three samples after a read strobe
  p_read_src_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag_o[NERR-1]) |-> $past(rd_smp_i, 3));

  for (genvar i = 0; i < NERR; i++) begin : g_kind
    // R11: a counter is non-zero exactly when its flag is set
    p_flag_cnt_r11: assert property (@(posedge clk) disable iff (rst)
      (err_cnt_o[i*CNT_W +: CNT_W] != '0) == err_flag_o[i]);

    // R11: a saturated counter stays saturated until cleared
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
      ((err_cnt_o[i*CNT_W +: CNT_W] == '1) && !clr_i)
        |=> (err_cnt_o[i*CNT_W +: CNT_W] == '1));
  end

endmodule

bind sram_timing_monitor smon_checker #(.NERR(smon_pkg::NERR), .CNT_W(CNT_W)) u_smon_checker (
  .clk        (clk),
  .rst        (rst),
  .clr_i      (clr_i),
  .rd_smp_i   (rd_smp_i),
  .err_flag_o (err_flag_o),
  .err_cnt_o  (err_cnt_o)
);

// File: tb/test_sram_timing_monitor.sv
`timescale 1ns/1ps
module test_sram_timing_monitor;

  localparam int AW = 19;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int NE = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, clr = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din  = '0;
  logic [NE-1:0] flags;
  logic [NE*CW-1:0] cnts;

  int checks = 0, fails = 0;
  bit done = 0;

  sram_timing_monitor #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) i_sram_timing_monitor (
    .clk(clk), .rst(rst), .clr_i(clr), .cs_n_i(cs_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .addr_i(addr), .din_i(din), .rd_smp_i(rd), .err_flag_o(flags), .err_cnt_o(cnts)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cnt(int i);
    return 32'(cnts[i*CW +: CW]);
  endfunction

  task automatic clear();
    clr = 1'b1; step(1); clr = 1'b0; step(2);
  endtask

  // Write with cs leading we by 'lead' ticks; window of 'wlen' ticks.
  task automatic wr(int lead, int wlen);
    addr = addr + 1; din = din + 8'h11; cs_n = 1'b0;
    step(lead); we_n = 1'b0; step(wlen); we_n = 1'b1;
    step(2); cs_n = 1'b1; step(14);
  endtask

  task automatic t_reset();
    chk("R1 flags after reset", 32'(flags), 0);
    for (int i = 0; i < NE; i++) chk("R1 counter after reset", cnt(i), 0);
  endtask

  task automatic t_lone_strobes();
    clear();
    we_n = 1'b0; step(3); we_n = 1'b1; step(4);
    addr = addr + 1; cs_n = 1'b0; step(3); cs_n = 1'b1; step(10);
    chk("R2 single strobe makes no write error", 32'(flags), 0);
  endtask

  task automatic t_pulse_width();
    clear();
    wr(10, 7);
    chk("R12 window of limit+1 accepted", 32'(flags), 0);
    wr(10, 6);
    chk("R3 short window flag", 32'(flags), 32'h01);
    chk("R3 short window count", cnt(0), 1);
  endtask

  // Chip select opens and closes the window; we held low around it.
  task automatic cs_win(int len);
    addr = addr + 1; din = din + 8'h05; we_n = 1'b0;
    step(10); cs_n = 1'b0; step(len); cs_n = 1'b1;
    step(2); we_n = 1'b1; step(14);
  endtask

  task automatic t_cs_window();
    clear();
    cs_win(8);
    chk("R4 cs window of limit+1 accepted", 32'(flags), 0);
    cs_win(7);
    chk("R4 cs fall to end too short", 32'(flags), 32'h02);
    cs_win(4);
    chk("R3 cs-ended short window flags", 32'(flags), 32'h03);
    chk("R3 cs-ended short window count", cnt(0), 1);
    chk("R4 cs-to-end count", cnt(1), 2);
  endtask

  task automatic dsu(int k);
    addr = addr + 1; cs_n = 1'b0; step(10);
    we_n = 1'b0; step(8); din = din + 8'h3C; step(k); we_n = 1'b1;
    step(2); cs_n = 1'b1; step(14);
  endtask

  task automatic t_data_setup();
    clear();
    dsu(3);
    chk("R5 data setup of limit+1 accepted", 32'(flags), 0);
    dsu(2);
    chk("R5 data setup violation", 32'(flags), 32'h04);
    chk("R5 data setup count", cnt(2), 1);
  endtask

  task automatic asu(int wlen);
    cs_n = 1'b0; step(10);
    we_n = 1'b0; addr = addr + 1; step(wlen); we_n = 1'b1;
    step(2); cs_n = 1'b1; step(14);
  endtask

  task automatic t_addr();
    clear();
    asu(8);
    chk("R6 address setup of limit+1 accepted", 32'(flags), 0);
    asu(7);
    chk("R6 address setup violation only", 32'(flags), 32'h08);
    clear();
    cs_n = 1'b0; step(10); we_n = 1'b0; step(3);
    addr = addr + 1; step(7); we_n = 1'b1; step(2); cs_n = 1'b1; step(14);
    chk("R7 address moved in window flags", 32'(flags), 32'h18);
    chk("R7 address moved count", cnt(4), 1);
  endtask

  task automatic pair(int gap);
    addr = addr + 1; cs_n = 1'b0; step(10);
    we_n = 1'b0; step(7); we_n = 1'b1; step(gap);
    we_n = 1'b0; step(7); we_n = 1'b1; step(2); cs_n = 1'b1; step(14);
  endtask

  task automatic t_gap_cycle();
    clear();
    pair(5);
    chk("R8 gap of limit+1 accepted", 32'(flags), 0);
    pair(4);
    chk("R8 gap violation", 32'(flags), 32'h20);
    pair(3);
    chk("R8 gap and cycle violations", 32'(flags), 32'h60);
    chk("R8 gap count", cnt(5), 2);
    chk("R8 cycle count", cnt(6), 1);
  endtask

  task automatic rd_pulse();
    rd = 1'b1; step(1); rd = 1'b0; step(3);
  endtask

  task automatic t_read();
    clear();
    addr = addr + 1; cs_n = 1'b0; oe_n = 1'b0; step(15);
    rd_pulse(); cs_n = 1'b1; oe_n = 1'b1; step(8);
    chk("R12 read at limit flagged", 32'(flags), 32'h80);
    addr = addr + 1; cs_n = 1'b0; oe_n = 1'b0; step(16);
    rd_pulse(); cs_n = 1'b1; oe_n = 1'b1; step(8);
    chk("R12 read at limit+1 accepted", cnt(7), 1);
    addr = addr + 1; cs_n = 1'b0; oe_n = 1'b0; step(20);
    addr = addr + 1; step(5);
    rd_pulse(); cs_n = 1'b1; oe_n = 1'b1; step(8);
    chk("R9 address change restarts access", cnt(7), 2);
    addr = addr + 1; cs_n = 1'b0; step(3);
    rd_pulse(); cs_n = 1'b1; step(8);
    chk("R9 strobe ignored with output disabled", cnt(7), 2);
  endtask

  task automatic t_saturate();
    clear();
    addr = addr + 1; cs_n = 1'b0; step(10);
    for (int n = 0; n < 17; n++) begin
      we_n = 1'b0; step(2); we_n = 1'b1; step(6);
    end
    cs_n = 1'b1; step(10);
    chk("R11 pulse counter saturates", cnt(0), 15);
    chk("R11 cycle counter saturates", cnt(6), 15);
    chk("R11 flags for burst", 32'(flags), 32'h41);
  endtask

  task automatic t_sticky_clear();
    step(30);
    chk("R10 flags stay set", 32'(flags), 32'h41);
    clear();
    chk("R10 clear empties flags", 32'(flags), 0);
    chk("R10 clear empties counter", cnt(0), 0);
  endtask

  initial begin
    step(4); rst = 1'b0; step(4);
    t_reset();
    t_lone_strobes();
    t_pulse_width();
    t_cs_window();
    t_data_setup();
    t_addr();
    t_gap_cycle();
    t_read();
    t_saturate();
    t_sticky_clear();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule